// File: doc/BRIEF.md
# Bit-Serial Clock-Chip Register Access Master

This block is the host-side engine for an external real-time clock chip that exposes its registers over four wires: an active-low chip select, an active-low write strobe, an active-low read strobe and one shared data line. Only one bit moves per chip-select pulse. The data line is half-duplex, so the block drives it for write bits and releases it for read bits. The pad's tristate buffer is controlled through a separate output-enable signal.

A host issues one request at a time through a valid/ready handshake. There are three kinds of request. A register write sends a four-bit address and then a data byte. A register read sends the address and then collects a byte. A resynchronisation burst performs eight dummy reads so that the external chip is back at the start of a cycle. Addresses flagged in a parameter bitmap are commands, and a write to one of them sends only the address. All strobe widths and gaps come from a single hold length derived from the system clock frequency. The block pulses `done` once when a request completes.

Top module: `serial_rtc_master`

## Requirements
- R1: During and after reset, chip select, write strobe and read strobe are high, output enable and `done` are low, and `req_ready` is high.
- R2: Every write or read request first sends the four address bits, bit 0 first. Each bit is carried by its own chip-select pulse.
- R3: A write to a non-command address sends 8 data bits after the address, bit 0 first. A write to an address whose bit is set in `CMD_MASK` (by default addresses 14 and 15) sends only the address.
- R4: For a write bit, output enable rises with the bit value on `rtc_dq_o` one cycle before chip select and write strobe fall. Both stay low for H cycles. The write strobe rises one cycle before chip select.
- R5: For a read bit, output enable is low for at least one cycle before the read strobe falls. Chip select and the read strobe stay low for 2*H cycles. The line is sampled at the end of the H-th low cycle, and the read strobe rises one cycle before chip select.
- R6: A read returns the collected byte on `rdata` with the first bit received in bit 0.
- R7: Between consecutive bits of one request, chip select stays high for exactly H+2 cycles.
- R8: `req_op` 00 is a write, 01 is a read, and 1x is a resync. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the cycle after the last bit's gap. In that cycle `done` is high for one cycle, `req_ready` returns high and `rdata` is valid.
- R9: A resync performs 8 single-bit reads with no address phase and leaves `rdata` unchanged.
- R10: The hold length is H = ceil(CLK_HZ / 1,000,000) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_op | input | 2 | 00 write, 01 read, 1x resync |
| req_addr | input | 4 | Register or command address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Engine idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte collected by the last read |
| rtc_cs_n | output | 1 | Chip select, active low |
| rtc_wr_n | output | 1 | Write strobe, active low |
| rtc_rd_n | output | 1 | Read strobe, active low |
| rtc_dq_o | output | 1 | Data line output value |
| rtc_dq_oe | output | 1 | Data line output enable |
| rtc_dq_i | input | 1 | Data line input value |

## Verification
The assertions assume that `rtc_dq_i` is stable while the read strobe is low, and that the host holds its request fields steady in the cycle the request is taken. The bench keeps to both. Its external-chip model changes the returned bit only on a rising read strobe. Its driver raises `req_valid` only on a falling clock edge and removes it right after the accepting edge.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_HOLD,
        PH_REL,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        OP_WR   = 2'b00,
        OP_RD   = 2'b01,
        OP_SYNC = 2'b10
    } op_e;

    function automatic int hold_cycles(input int hz);
        int c;
        c = (hz + 999_999) / 1_000_000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/srm_bit_phy.sv
module srm_bit_phy
    import srm_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int CNT_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_start,
    input  logic bit_is_rd,
    input  logic bit_val,
    output logic bit_done,
    output logic bit_rx,
    output logic cs_n,
    output logic wr_n,
    output logic rd_n,
    output logic dq_o,
    output logic dq_oe,
    input  logic dq_i
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic             is_rd;
        logic             val;
        logic [CNT_W-1:0] cnt;
        logic             rx;
    } phy_st_t;

    phy_st_t st_d, st_q;
    logic    fin_d;

    always_comb begin
        st_d  = st_q;
        fin_d = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (bit_start) begin
                    st_d.ph    = PH_SETUP;
                    st_d.is_rd = bit_is_rd;
                    st_d.val   = bit_val;
                end
            end
            PH_SETUP: begin
                st_d.ph  = PH_ACT;
                st_d.cnt = CNT_LOAD;
            end
            PH_ACT: begin
                if (st_q.cnt == '0) begin
                    if (st_q.is_rd) begin
                        st_d.rx  = dq_i;
                        st_d.ph  = PH_HOLD;
                        st_d.cnt = CNT_LOAD;
                    end else begin
                        st_d.ph = PH_REL;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.ph = PH_REL;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_REL: begin
                st_d.ph  = PH_GAP;
                st_d.cnt = CNT_LOAD;
            end
            PH_GAP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph = PH_IDLE;
                    fin_d   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, is_rd: 1'b0, val: 1'b0, cnt: '0, rx: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_done = fin_d;
    assign bit_rx   = st_q.rx;
    assign cs_n     = !(st_q.ph inside {PH_ACT, PH_HOLD, PH_REL});
    assign wr_n     = !((st_q.ph == PH_ACT) && !st_q.is_rd);
    assign rd_n     = !((st_q.ph inside {PH_ACT, PH_HOLD}) && st_q.is_rd);
    assign dq_oe    = (st_q.ph != PH_IDLE) && !st_q.is_rd;
    assign dq_o     = dq_oe && st_q.val;

    // R4: the two strobes never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    // R4: a strobe is only ever low inside a chip-select pulse
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> !cs_n);

    // R4: chip select rises only after both strobes were already high
    p_strobe_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(wr_n) && $past(rd_n)));

    // R5: the line is released at least a cycle before the read strobe falls
    p_release_before_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(dq_oe));

    // R5: no drive while the read strobe is low
    p_no_drive_in_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !dq_oe);

endmodule

// File: rtl/srm_xfer_ctrl.sv
module srm_xfer_ctrl
    import srm_pkg::*;
#(
    parameter logic [15:0] CMD_MASK = 16'hC000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [3:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       done,
    output logic [7:0] rdata,
    output logic       bit_start,
    output logic       bit_is_rd,
    output logic       bit_val,
    input  logic       bit_done,
    input  logic       bit_rx
);

    localparam logic [3:0] LAST_CMD  = 4'd3;
    localparam logic [3:0] LAST_SYNC = 4'd7;
    localparam logic [3:0] LAST_FULL = 4'd11;

    typedef struct packed {
        logic       busy;
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [3:0] idx;
        logic [3:0] last;
        logic       issued;
        logic [7:0] shreg;
        logic       done;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    addr_phase;
    logic    is_sync;
    logic    cur_rd;
    logic [3:0] data_idx;

    assign is_sync    = st_q.op[1];
    assign addr_phase = !is_sync && (st_q.idx < 4'd4);
    assign cur_rd     = !addr_phase && (st_q.op != OP_WR);
    assign data_idx   = st_q.idx - 4'd4;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy   = 1'b1;
                st_d.op     = req_op;
                st_d.addr   = req_addr;
                st_d.wdata  = req_wdata;
                st_d.idx    = '0;
                st_d.issued = 1'b0;
                if (req_op[1])                               st_d.last = LAST_SYNC;
                else if (req_op == OP_WR && CMD_MASK[req_addr]) st_d.last = LAST_CMD;
                else                                         st_d.last = LAST_FULL;
            end
        end else begin
            if (bit_start) st_d.issued = 1'b1;
            if (bit_done) begin
                st_d.issued = 1'b0;
                if (cur_rd && st_q.op == OP_RD) st_d.shreg = {bit_rx, st_q.shreg[7:1]};
                if (st_q.idx == st_q.last) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_start = st_q.busy && !st_q.issued;
    assign bit_is_rd = cur_rd;
    assign bit_val   = addr_phase ? st_q.addr[st_q.idx[1:0]] : st_q.wdata[data_idx[2:0]];
    assign req_ready = !st_q.busy;
    assign done      = st_q.done;
    assign rdata     = st_q.shreg;

    // R8: once a request is taken the engine reports busy
    p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion always follows the end of a bit
    p_done_after_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_done));

    // R3: the bit index never runs past the request's length
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.idx <= st_q.last));

endmodule

// File: rtl/serial_rtc_master.sv
module serial_rtc_master
    import srm_pkg::*;
#(
    parameter int          CLK_HZ   = 4_000_000,
    parameter logic [15:0] CMD_MASK = 16'hC000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [3:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       done,
    output logic [7:0] rdata,
    output logic       rtc_cs_n,
    output logic       rtc_wr_n,
    output logic       rtc_rd_n,
    output logic       rtc_dq_o,
    output logic       rtc_dq_oe,
    input  logic       rtc_dq_i
);

    localparam int HOLD_CYC = hold_cycles(CLK_HZ);
    localparam int CNT_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic bit_start, bit_is_rd, bit_val, bit_done, bit_rx;

    srm_xfer_ctrl #(.CMD_MASK(CMD_MASK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata),
        .bit_start (bit_start),
        .bit_is_rd (bit_is_rd),
        .bit_val   (bit_val),
        .bit_done  (bit_done),
        .bit_rx    (bit_rx)
    );

    srm_bit_phy #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_start (bit_start),
        .bit_is_rd (bit_is_rd),
        .bit_val   (bit_val),
        .bit_done  (bit_done),
        .bit_rx    (bit_rx),
        .cs_n      (rtc_cs_n),
        .wr_n      (rtc_wr_n),
        .rd_n      (rtc_rd_n),
        .dq_o      (rtc_dq_o),
        .dq_oe     (rtc_dq_oe),
        .dq_i      (rtc_dq_i)
    );

endmodule

// File: tb/tb_serial_rtc_master.sv
module tb_serial_rtc_master;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int H          = ((CLK_HZ + 999_999) / 1_000_000 < 1) ? 1 : (CLK_HZ + 999_999) / 1_000_000; // R10

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [3:0] req_addr = 4'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       req_ready, done;
    logic [7:0] rdata;
    logic       rtc_cs_n, rtc_wr_n, rtc_rd_n, rtc_dq_o, rtc_dq_oe, rtc_dq_i;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rtc_master #(.CLK_HZ(CLK_HZ), .CMD_MASK(16'hC000)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .rtc_cs_n(rtc_cs_n), .rtc_wr_n(rtc_wr_n),
        .rtc_rd_n(rtc_rd_n), .rtc_dq_o(rtc_dq_o), .rtc_dq_oe(rtc_dq_oe),
        .rtc_dq_i(rtc_dq_i)
    );

    // external chip model: returns pattern bits, next bit on each read strobe rise
    logic [7:0] spat = 8'h00;
    logic [3:0] k = 4'd0;
    assign rtc_dq_i = spat[k[2:0]];
    always @(posedge rtc_rd_n) k <= k + 4'd1;

    // independent strobe observers
    logic [11:0] cap = '0;
    int nw = 0;
    int nr = 0;
    always @(negedge rtc_wr_n) if (rst_n) begin
        if (nw < 12) cap[nw] <= rtc_dq_o;
        nw <= nw + 1;
    end
    always @(negedge rtc_rd_n) if (rst_n) nr <= nr + 1;

    typedef struct {
        bit cs; bit wr; bit rd; bit oe; bit dq; bit rdy; bit dn; bit [7:0] rb;
    } exp_t;
    exp_t eq[$];
    logic [7:0] model_rdata = 8'h00;
    bit checking = 1'b0;

    task automatic push(bit cs, bit wr, bit rd, bit oe, bit dq, bit rdy, bit dn);
        exp_t e;
        e.cs = cs; e.wr = wr; e.rd = rd; e.oe = oe; e.dq = dq;
        e.rdy = rdy; e.dn = dn; e.rb = model_rdata;
        eq.push_back(e);
    endtask

    task automatic push_bit(bit is_rd, bit v);
        push(1, 1, 1, 0, 0, 0, 0);                          // engine issues the bit
        push(1, 1, 1, !is_rd, !is_rd && v, 0, 0);          // set-up cycle
        if (!is_rd) begin
            for (int i = 0; i < H; i++) push(0, 0, 1, 1, v, 0, 0);
            push(0, 1, 1, 1, v, 0, 0);
            for (int i = 0; i < H; i++) push(1, 1, 1, 1, v, 0, 0);
        end else begin
            for (int i = 0; i < 2*H; i++) push(0, 1, 0, 0, 0, 0, 0);
            push(0, 1, 1, 0, 0, 0, 0);
            for (int i = 0; i < H; i++) push(1, 1, 1, 0, 0, 0, 0);
        end
    endtask

    function automatic bit is_cmd(input logic [3:0] a);
        return (a == 4'd14) || (a == 4'd15);                 // R3 default commands
    endfunction

    always @(negedge clk) begin : chk
        exp_t e;
        if (rst_n && checking) begin
            if (eq.size() > 0) e = eq.pop_front();
            else begin
                e.cs = 1; e.wr = 1; e.rd = 1; e.oe = 0; e.dq = 0;
                e.rdy = 1; e.dn = 0; e.rb = model_rdata;
            end
            tests++;
            if (rtc_wr_n !== e.wr || (e.oe && rtc_dq_o !== e.dq)) begin
                fails++;
                $display("FAIL R4 wr/dq: got wr=%0b dq=%0b expected wr=%0b dq=%0b at %0t",
                         rtc_wr_n, rtc_dq_o, e.wr, e.dq, $time);
            end else if (rtc_rd_n !== e.rd || rtc_dq_oe !== e.oe) begin
                fails++;
                $display("FAIL R5 rd/oe: got rd=%0b oe=%0b expected rd=%0b oe=%0b at %0t",
                         rtc_rd_n, rtc_dq_oe, e.rd, e.oe, $time);
            end else if (rtc_cs_n !== e.cs) begin
                fails++;
                $display("FAIL R7 cs: got %0b expected %0b at %0t", rtc_cs_n, e.cs, $time);
            end else if (req_ready !== e.rdy || done !== e.dn) begin
                fails++;
                $display("FAIL R8 ready/done: got %0b/%0b expected %0b/%0b at %0t",
                         req_ready, done, e.rdy, e.dn, $time);
            end else if (e.dn && rdata !== e.rb) begin
                fails++;
                $display("FAIL R6 rdata: got %02h expected %02h", rdata, e.rb);
            end
        end
    end

    task automatic check(bit ok, string tag, int got, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic do_req(logic [1:0] op, logic [3:0] a, logic [7:0] wd, logic [7:0] pat);
        int ew, er;
        @(negedge clk);
        nw = 0; nr = 0; k = 4'd0; spat = pat; cap = '0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (!op[1]) for (int i = 0; i < 4; i++) push_bit(0, a[i]);
        if (op == 2'b00 && !is_cmd(a)) for (int i = 0; i < 8; i++) push_bit(0, wd[i]);
        if (op != 2'b00) for (int i = 0; i < 8; i++) push_bit(1, 1'b0);
        if (op == 2'b01) model_rdata = pat;                  // R6 first bit into bit 0
        push(1, 1, 1, 0, 0, 1, 1);
        while (eq.size() != 0) @(posedge clk);
        @(negedge clk);
        ew = op[1] ? 0 : ((op == 2'b00 && !is_cmd(a)) ? 12 : 4);
        er = (op == 2'b00) ? 0 : 8;
        if (op[1]) check(nw == ew && nr == er, "R9 resync strobe count", nw*16 + nr, ew*16 + er);
        else if (op == 2'b00) check(nw == ew && nr == er, "R3 write strobe count", nw*16 + nr, ew*16 + er);
        else check(nw == ew && nr == er, "R2 read strobe count", nw*16 + nr, ew*16 + er);
        if (!op[1]) check(cap[3:0] == a, "R2 address bits", int'(cap[3:0]), int'(a));
        if (op == 2'b00 && !is_cmd(a)) check(cap[11:4] == wd, "R3 data bits", int'(cap[11:4]), int'(wd));
        if (op == 2'b01) check(rdata == pat, "R6 read byte", int'(rdata), int'(pat));
        if (op[1]) check(rdata == model_rdata, "R9 rdata kept", int'(rdata), int'(model_rdata));
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                check(rtc_cs_n && rtc_wr_n && rtc_rd_n && !rtc_dq_oe && !done && req_ready,
                      "R1 reset state",
                      {rtc_cs_n, rtc_wr_n, rtc_rd_n, rtc_dq_oe, done, req_ready}, 6'b111001);
                rst_n = 1'b1;
                checking = 1'b1;
                repeat (2) @(posedge clk);
                do_req(2'b00, 4'd3,  8'hA5, 8'h00);   // R3 R4 R7 full write
                do_req(2'b01, 4'd3,  8'h00, 8'h5C);   // R5 R6 read
                do_req(2'b00, 4'd15, 8'hFF, 8'h00);   // R3 command, address only
                do_req(2'b10, 4'd0,  8'h00, 8'hFF);   // R9 resync
                do_req(2'b11, 4'd9,  8'h12, 8'hAA);   // R9 op 11 also resync
                do_req(2'b01, 4'hA,  8'h00, 8'h81);   // R6 edge bits
                do_req(2'b00, 4'd7,  8'hFF, 8'h00);   // R4 all ones
                do_req(2'b00, 4'd14, 8'h3C, 8'h00);   // R3 second command
                do_req(2'b00, 4'd0,  8'h00, 8'h00);   // R4 all zeros
                repeat (5) @(posedge clk);
            end
            begin
                repeat (150_000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule